// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block is the receive side of a descriptor-driven network controller. A MAC hands it received frames one byte per cycle, with start-of-frame and end-of-frame markers and a CRC-error flag at the end. Software keeps a ring of four-word receive descriptors in memory. The engine walks that ring through a single word-addressed memory port with a one-cycle read latency. It copies each frame into the buffer that the current descriptor names. It then writes the descriptor's status word back with ownership returned to software, the received length (CRC bytes included) and a set of error flags.

While idle, the engine keeps re-reading the current descriptor. It therefore knows at the first byte whether a buffer is available. If none is, the frame is thrown away and a missed-frame counter is bumped. Frames are accepted only while the receive-enable input is high at the start of the frame. The MAC must leave at least eight idle cycles between the end of one frame and the start of the next. In that gap the engine writes the status back and fetches the next descriptor.

Top module: `rxd_ring_engine`

## Requirements
- R1: Descriptor i starts at memory word `ring_base + 4*i`. Word 0 of a descriptor is status and word 2 holds the buffer byte address (4-byte aligned). Frame data goes to the words starting at that byte address divided by four.
- R2: Frame byte k is stored at buffer byte offset k, little-endian within each 32-bit word (byte lane k mod 4 = bits 8*(k mod 4)+7 down to 8*(k mod 4)). Only lanes that hold frame bytes are enabled in the write.
- R3: The status write-back clears bit 31 (owned), keeps bit 30 (end of ring) as armed, and sets bits 12:0 to the number of bytes received including the 4 CRC bytes, saturated at 8191. Bits 29:23, 18:13 and all unflagged error bits are zero.
- R4: Bytes at offsets at or above the buffer size (bits 12:0 of the armed status word) are not written, and such a frame gets the overlong flag, bit 22.
- R5: A frame longer than `max_len` bytes gets the overlong flag, bit 22.
- R6: A frame shorter than 64 bytes gets the runt flag, bit 20.
- R7: A frame whose last byte carries `in_crc_bad` gets the CRC flag, bit 19.
- R8: The summary error bit 21 is set exactly when bit 19, 20 or 22 is set.
- R9: After a write-back the engine moves to the next descriptor. After a descriptor armed with bit 30 it returns to descriptor 0.
- R10: If the current descriptor is not owned (bit 31 clear) when a frame starts, the frame writes nothing, `miss_count` rises by one, and the next frame is offered to the same descriptor.
- R11: `miss_clr` sets `miss_count` to zero on the next clock; a clear in the same cycle as a missed frame start wins.
- R12: A frame whose first byte arrives while `rx_en` is low is ignored: no memory write and no change to `miss_count`.
- R13: During and right after synchronous reset, `miss_count` is zero, no memory request is issued, and the engine starts at descriptor 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receive enable, sampled at each frame start |
| ring_base | input | AW | Word address of descriptor 0 |
| max_len | input | MW | Largest frame length accepted without the overlong flag |
| miss_clr | input | 1 | Clears the missed-frame counter |
| miss_count | output | MISS_W | Missed-frame counter |
| in_valid | input | 1 | Byte valid from the MAC |
| in_sof | input | 1 | First byte of a frame |
| in_eof | input | 1 | Last byte of a frame |
| in_data | input | 8 | Frame byte |
| in_crc_bad | input | 1 | CRC error, qualified by the last byte |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Write (1) or read (0) |
| mem_addr | output | AW | Memory word address |
| mem_be | output | 4 | Byte enables for writes |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after the request is taken |

## Verification
Directed frames of 64, 40, 100 and 150 bytes, each in its own descriptor, separate a good frame from the runt, CRC and max-length flags. A one-byte frame exercises the start-and-end-in-one-cycle path. A frame longer than its buffer separates truncation from the max-length check, because it checks both the stored bytes and the guard bytes beyond them. Frames offered to an unowned descriptor and frames offered with receive disabled tell dropping-with-count apart from ignoring. A clear aligned with a missed frame start shows which of the two wins. Random lengths, buffer sizes, CRC errors and idle gaps inside frames across several ring wraps check lane packing, partial last words and ring walking against a bench model.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
  localparam int OWN_B  = 31;
  localparam int EOR_B  = 30;
  localparam int OVER_B = 22;
  localparam int ERR_B  = 21;
  localparam int RUNT_B = 20;
  localparam int CRC_B  = 19;
  localparam int LEN_W  = 13;
  localparam int LEN_SAT = (1 << LEN_W) - 1;
  localparam int RUNT_LIMIT = 64;
  localparam int BUF_WORD_OFS = 2;

  typedef enum logic [2:0] {
    ST_PA, ST_PB, ST_PC, ST_PD, ST_RECV, ST_DROP, ST_WB
  } rxd_state_t;
endpackage

// File: rtl/rxd_packer.sv
module rxd_packer #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          vld,
  input  logic          first,
  input  logic          last,
  input  logic          keep,
  input  logic [7:0]    din,
  output logic [CW-1:0] kidx,
  output logic [CW-1:0] cnt_next,
  output logic          emit,
  output logic [31:0]   emit_word,
  output logic [3:0]    emit_be,
  output logic [CW-3:0] emit_off
);
  logic [CW-1:0] cnt_q;
  logic [31:0]   acc_q;
  logic [3:0]    be_q;
  logic [1:0]    lane;

  always_comb begin
    kidx      = first ? '0 : cnt_q;
    lane      = kidx[1:0];
    cnt_next  = (kidx == {CW{1'b1}}) ? kidx : kidx + 1'b1;
    emit_word = first ? 32'd0 : acc_q;
    emit_word[8*lane +: 8] = din;
    emit_be   = (first ? 4'd0 : be_q) | (keep ? (4'b0001 << lane) : 4'd0);
    emit      = vld && ((lane == 2'd3) || last);
    emit_off  = kidx[CW-1:2];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      acc_q <= '0;
      be_q  <= '0;
    end else if (vld) begin
      cnt_q <= cnt_next;
      if (emit) begin
        acc_q <= '0;
        be_q  <= '0;
      end else begin
        acc_q <= emit_word;
        be_q  <= emit_be;
      end
    end
  end
endmodule

// File: rtl/rxd_stat_enc.sv
module rxd_stat_enc
  import rxd_pkg::*;
#(
  parameter int CW = 16,
  parameter int MW = 16
) (
  input  logic [CW-1:0]    tot,
  input  logic [LEN_W-1:0] bsz,
  input  logic [MW-1:0]    max_len,
  input  logic             crc_bad,
  input  logic             eor,
  output logic [31:0]      word
);
  logic over, runt;

  always_comb begin
    over = (32'(tot) > 32'(bsz)) || (32'(tot) > 32'(max_len));
    runt = 32'(tot) < 32'(RUNT_LIMIT);
    word = 32'd0;
    word[EOR_B]  = eor;
    word[LEN_W-1:0] = (32'(tot) > 32'(LEN_SAT)) ? LEN_W'(LEN_SAT) : tot[LEN_W-1:0];
    word[CRC_B]  = crc_bad;
    word[RUNT_B] = runt;
    word[OVER_B] = over;
    word[ERR_B]  = crc_bad | runt | over;
  end
endmodule

// File: rtl/rxd_miss_ctr.sv
module rxd_miss_ctr #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst || clr)
      count <= '0;
    else if (inc)
      count <= count + 1'b1;
  end
endmodule

// File: rtl/rxd_ring_engine.sv
module rxd_ring_engine
  import rxd_pkg::*;
#(
  parameter int AW     = 16,
  parameter int IW     = 6,
  parameter int CW     = 16,
  parameter int MW     = 16,
  parameter int MISS_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_en,
  input  logic [AW-1:0]     ring_base,
  input  logic [MW-1:0]     max_len,
  input  logic              miss_clr,
  output logic [MISS_W-1:0] miss_count,
  input  logic              in_valid,
  input  logic              in_sof,
  input  logic              in_eof,
  input  logic [7:0]        in_data,
  input  logic              in_crc_bad,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [3:0]        mem_be,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata
);
  rxd_state_t state;

  logic [IW-1:0]    idx_q;
  logic             own_q, eor_q, desc_vld_q;
  logic [LEN_W-1:0] bsz_q;
  logic [AW-1:0]    bufw_q;
  logic [CW-1:0]    tot_q;
  logic             crc_q;
  logic             stat_wr_q;

  logic [AW-1:0] desc_addr;
  logic          poll_st, sof_hit, owned, accept, miss_inc;
  logic          pk_vld, pk_keep, pk_emit;
  logic [CW-1:0] pk_kidx, pk_cnt_next;
  logic [31:0]   pk_word, enc_word;
  logic [3:0]    pk_be;
  logic [CW-3:0] pk_off;

  always_comb begin
    desc_addr = ring_base + AW'({idx_q, 2'b00});
    poll_st   = (state == ST_PA) || (state == ST_PB) || (state == ST_PC) || (state == ST_PD);
    sof_hit   = poll_st && in_valid && in_sof && rx_en;
    owned     = desc_vld_q && own_q;
    accept    = sof_hit && owned;
    miss_inc  = sof_hit && !owned;
    pk_vld    = accept || ((state == ST_RECV) && in_valid);
    pk_keep   = 32'(pk_kidx) < 32'(bsz_q);
  end

  rxd_packer #(.CW(CW)) u_pack (
    .clk(clk), .rst(rst), .vld(pk_vld), .first(accept), .last(in_eof),
    .keep(pk_keep), .din(in_data), .kidx(pk_kidx), .cnt_next(pk_cnt_next),
    .emit(pk_emit), .emit_word(pk_word), .emit_be(pk_be), .emit_off(pk_off)
  );

  rxd_stat_enc #(.CW(CW), .MW(MW)) u_enc (
    .tot(tot_q), .bsz(bsz_q), .max_len(max_len), .crc_bad(crc_q),
    .eor(eor_q), .word(enc_word)
  );

  rxd_miss_ctr #(.W(MISS_W)) u_miss (
    .clk(clk), .rst(rst), .clr(miss_clr), .inc(miss_inc), .count(miss_count)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_PA;
      idx_q      <= '0;
      own_q      <= 1'b0;
      eor_q      <= 1'b0;
      bsz_q      <= '0;
      bufw_q     <= '0;
      desc_vld_q <= 1'b0;
      tot_q      <= '0;
      crc_q      <= 1'b0;
      stat_wr_q  <= 1'b0;
      mem_req    <= 1'b0;
      mem_we     <= 1'b0;
      mem_addr   <= '0;
      mem_be     <= '0;
      mem_wdata  <= '0;
    end else begin
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      stat_wr_q <= 1'b0;
      if (pk_vld && pk_emit && (|pk_be)) begin
        mem_req   <= 1'b1;
        mem_we    <= 1'b1;
        mem_addr  <= bufw_q + AW'(pk_off);
        mem_be    <= pk_be;
        mem_wdata <= pk_word;
      end
      if (accept) begin
        if (in_eof) begin
          tot_q <= pk_cnt_next;
          crc_q <= in_crc_bad;
          state <= ST_WB;
        end else begin
          state <= ST_RECV;
        end
      end else if (miss_inc) begin
        desc_vld_q <= 1'b0;
        state      <= in_eof ? ST_PA : ST_DROP;
      end else begin
        case (state)
          ST_PA: begin
            mem_req  <= 1'b1;
            mem_addr <= desc_addr;
            state    <= ST_PB;
          end
          ST_PB: begin
            mem_req  <= 1'b1;
            mem_addr <= desc_addr + AW'(BUF_WORD_OFS);
            state    <= ST_PC;
          end
          ST_PC: begin
            own_q <= mem_rdata[OWN_B];
            eor_q <= mem_rdata[EOR_B];
            bsz_q <= mem_rdata[LEN_W-1:0];
            state <= ST_PD;
          end
          ST_PD: begin
            bufw_q     <= mem_rdata[AW+1:2];
            desc_vld_q <= 1'b1;
            state      <= ST_PA;
          end
          ST_RECV: begin
            if (in_valid && in_eof) begin
              tot_q <= pk_cnt_next;
              crc_q <= in_crc_bad;
              state <= ST_WB;
            end
          end
          ST_DROP: begin
            if (in_valid && in_eof) state <= ST_PA;
          end
          ST_WB: begin
            mem_req    <= 1'b1;
            mem_we     <= 1'b1;
            mem_addr   <= desc_addr;
            mem_be     <= 4'hF;
            mem_wdata  <= enc_word;
            stat_wr_q  <= 1'b1;
            idx_q      <= eor_q ? '0 : idx_q + 1'b1;
            desc_vld_q <= 1'b0;
            state      <= ST_PA;
          end
          default: state <= ST_PA;
        endcase
      end
    end
  end
endmodule

// File: rtl/rxd_ring_checker.sv
module rxd_ring_checker #(
  parameter int MISS_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              miss_clr,
  input logic [MISS_W-1:0] miss_count,
  input logic              mem_req,
  input logic              mem_we,
  input logic [3:0]        mem_be,
  input logic [1:0]        addr_lo,
  input logic [1:0]        base_lo,
  input logic              wb_own,
  input logic              stat_wr
);
  // R13: reset leaves the counter at zero and the memory port quiet
  a_r13_reset_quiet: assert property (@(posedge clk)
    rst |=> (miss_count == '0 && !mem_req));

  // R3: a status write-back returns ownership and writes the full word
  a_r3_own_returned: assert property (@(posedge clk) disable iff (rst)
    stat_wr |-> (mem_req && mem_we && mem_be == 4'hF && !wb_own));

  // R1: status words sit on descriptor boundaries relative to the ring base
  a_r1_desc_boundary: assert property (@(posedge clk) disable iff (rst)
    stat_wr |-> (addr_lo == base_lo));

  // R4: no write request is ever issued with all lanes disabled
  a_r4_no_empty_write: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> (mem_be != 4'h0));

  // R11: a clear request empties the counter on the next clock
  a_r11_clear: assert property (@(posedge clk) disable iff (rst)
    miss_clr |=> (miss_count == '0));

  // R10: the counter moves by at most one per frame start
  a_r10_single_step: assert property (@(posedge clk) disable iff (rst)
    !miss_clr |=> (miss_count == $past(miss_count) || miss_count == $past(miss_count) + 1'b1));
endmodule

bind rxd_ring_engine rxd_ring_checker #(.MISS_W(MISS_W)) u_check (
  .clk(clk), .rst(rst), .miss_clr(miss_clr), .miss_count(miss_count),
  .mem_req(mem_req), .mem_we(mem_we), .mem_be(mem_be),
  .addr_lo(mem_addr[1:0]), .base_lo(ring_base[1:0]),
  .wb_own(mem_wdata[31]), .stat_wr(stat_wr_q)
);

// File: tb/rxd_ring_engine_test.sv
`timescale 1ns/1ps
module rxd_ring_engine_test;
  localparam int AW = 12;
  localparam int IW = 4;
  localparam int RING_BASE = 'h100;
  localparam int NDESC = 4;
  localparam int BUF0 = 'h1000;
  localparam int BSTRIDE = 'h400;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst, rx_en, miss_clr, in_valid, in_sof, in_eof, in_crc_bad;
  logic [AW-1:0] ring_base;
  logic [15:0] max_len;
  logic [31:0] miss_count;
  logic [7:0] in_data;
  logic mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [3:0] mem_be;
  logic [31:0] mem_wdata, mem_rdata;

  logic tb_wr;
  logic [AW-1:0] tb_waddr;
  logic [31:0] tb_wdata;
  logic [31:0] mem [0:(1<<AW)-1];

  int total = 0, fails = 0, exp_idx = 0, cur_max = 1518;
  bit done = 0;
  logic [7:0] fr [0:511];

  rxd_ring_engine #(.AW(AW), .IW(IW)) uut (
    .clk(clk), .rst(rst), .rx_en(rx_en), .ring_base(ring_base), .max_len(max_len),
    .miss_clr(miss_clr), .miss_count(miss_count), .in_valid(in_valid), .in_sof(in_sof),
    .in_eof(in_eof), .in_data(in_data), .in_crc_bad(in_crc_bad), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata)
  );

  always @(posedge clk) begin
    if (tb_wr) mem[tb_waddr] <= tb_wdata;
    else if (mem_req && mem_we)
      for (int b = 0; b < 4; b++)
        if (mem_be[b]) mem[mem_addr][8*b +: 8] <= mem_wdata[8*b +: 8];
    if (mem_req && !mem_we) mem_rdata <= mem[mem_addr];
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic poke(input int a, input logic [31:0] d);
    @(negedge clk);
    tb_wr = 1'b1; tb_waddr = AW'(a); tb_wdata = d;
    @(negedge clk);
    tb_wr = 1'b0;
  endtask

  function automatic logic [7:0] rd_byte(input int ba);
    return mem[ba >> 2][8*(ba % 4) +: 8];
  endfunction

  function automatic logic [31:0] arm_word(input int bsz, input bit own, input bit eor);
    return {own, eor, 17'd0, 13'(bsz)};
  endfunction

  function automatic logic [31:0] exp_stat(input int len, input int bsz, input int maxf,
                                           input bit crc, input bit eor);
    logic [31:0] s = 32'd0;
    bit over = (len > bsz) || (len > maxf);
    bit runt = len < 64;
    s[30] = eor;
    s[12:0] = (len > 8191) ? 13'h1FFF : 13'(len);
    s[19] = crc; s[20] = runt; s[22] = over; s[21] = crc | runt | over;
    return s;
  endfunction

  task automatic prefill(input int i, input int n);
    for (int w = 0; w <= (n + 11) / 4; w++)
      poke((BUF0 + i * BSTRIDE) / 4 + w, 32'hA5A5A5A5);
  endtask

  task automatic arm(input int i, input int bsz, input bit own);
    poke(RING_BASE + 4 * i, arm_word(bsz, own, i == NDESC - 1));
    poke(RING_BASE + 4 * i + 2, BUF0 + i * BSTRIDE);
  endtask

  task automatic gen(input int len);
    for (int k = 0; k < len; k++) fr[k] = 8'($urandom);
  endtask

  task automatic send(input int len, input bit crc, input bit gaps, input bit clr_sof);
    for (int k = 0; k < len; k++) begin
      if (gaps && k > 0 && $urandom_range(0, 3) == 0) begin
        @(negedge clk);
        in_valid = 0; in_sof = 0; in_eof = 0; in_crc_bad = 0; miss_clr = 0;
      end
      @(negedge clk);
      in_valid = 1; in_sof = (k == 0); in_eof = (k == len - 1); in_data = fr[k];
      in_crc_bad = crc && (k == len - 1); miss_clr = clr_sof && (k == 0);
    end
    @(negedge clk);
    in_valid = 0; in_sof = 0; in_eof = 0; in_crc_bad = 0; miss_clr = 0;
    repeat (12) @(negedge clk);
  endtask

  task automatic check_untouched(input int i, input string req);
    bit ok = 1;
    logic [7:0] a = 8'hA5;
    for (int k = 0; k < 8; k++)
      if (rd_byte(BUF0 + i * BSTRIDE + k) !== 8'hA5) begin ok = 0; a = rd_byte(BUF0 + i * BSTRIDE + k); end
    chk(ok, req, "buffer untouched", {24'd0, a}, 32'hA5);
  endtask

  task automatic check_frame(input int i, input int len, input int bsz, input bit crc,
                             input string sreq, input string breq);
    int n = (len < bsz) ? len : bsz;
    bit ok = 1;
    logic [7:0] a = 0, e = 0;
    logic [31:0] es = exp_stat(len, bsz, cur_max, crc, i == NDESC - 1);
    chk(mem[RING_BASE + 4 * i] === es, sreq, "status", mem[RING_BASE + 4 * i], es);
    for (int k = 0; k < n + 8; k++) begin
      logic [7:0] want = (k < n) ? fr[k] : 8'hA5;
      if (ok && rd_byte(BUF0 + i * BSTRIDE + k) !== want) begin
        ok = 0; a = rd_byte(BUF0 + i * BSTRIDE + k); e = want;
      end
    end
    chk(ok, breq, "buffer bytes", {24'd0, a}, {24'd0, e});
  endtask

  task automatic run_frame(input int len, input int bsz, input bit crc, input bit gaps,
                           input string sreq, input string breq);
    int i = exp_idx;
    prefill(i, (len < bsz) ? len : bsz);
    arm(i, bsz, 1'b1);
    repeat (8) @(negedge clk);
    gen(len);
    send(len, crc, gaps, 1'b0);
    check_frame(i, len, bsz, crc, sreq, breq);
    exp_idx = (i == NDESC - 1) ? 0 : i + 1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    rst = 1; rx_en = 0; miss_clr = 0; in_valid = 0; in_sof = 0; in_eof = 0;
    in_data = 0; in_crc_bad = 0; tb_wr = 0; tb_waddr = 0; tb_wdata = 0;
    ring_base = AW'(RING_BASE); max_len = 16'd1518;
    repeat (4) @(negedge clk);
    chk(mem_req == 1'b0, "R13", "mem_req in reset", {31'd0, mem_req}, 0);
    chk(miss_count == 0, "R13", "miss_count in reset", miss_count, 0);
    rst = 0;
    for (int i = 0; i < NDESC; i++) arm(i, 512, 1'b1);
    repeat (10) @(negedge clk);
    chk(mem[RING_BASE] === arm_word(512, 1, 0), "R13", "no write while idle",
        mem[RING_BASE], arm_word(512, 1, 0));
    rx_en = 1;

    run_frame(64, 512, 0, 0, "R3", "R1");
    run_frame(40, 512, 0, 0, "R6", "R2");
    run_frame(100, 512, 1, 0, "R7", "R2");
    chk(mem[RING_BASE + 8][21] === 1'b1, "R8", "summary bit", {31'd0, mem[RING_BASE + 8][21]}, 1);
    max_len = 16'd120; cur_max = 120;
    run_frame(150, 512, 0, 0, "R5", "R2");
    max_len = 16'd1518; cur_max = 1518;
    run_frame(80, 512, 0, 0, "R9", "R2");
    run_frame(100, 70, 0, 0, "R4", "R4");
    run_frame(1, 512, 0, 0, "R6", "R2");

    begin
      int i = exp_idx;
      prefill(i, 0);
      arm(i, 512, 1'b0);
      repeat (8) @(negedge clk);
      gen(50); send(50, 0, 0, 0);
      chk(miss_count == 1, "R10", "miss count", miss_count, 1);
      chk(mem[RING_BASE + 4 * i] === arm_word(512, 0, i == NDESC - 1), "R10", "status kept",
          mem[RING_BASE + 4 * i], arm_word(512, 0, i == NDESC - 1));
      check_untouched(i, "R10");
      send(50, 0, 0, 1);
      chk(miss_count == 0, "R11", "clear beats increment", miss_count, 0);
      send(50, 0, 0, 0);
      chk(miss_count == 1, "R10", "miss count again", miss_count, 1);
      @(negedge clk); miss_clr = 1;
      @(negedge clk); miss_clr = 0;
      @(negedge clk);
      chk(miss_count == 0, "R11", "clear pulse", miss_count, 0);
    end
    run_frame(90, 512, 0, 0, "R10", "R2");

    begin
      int i = exp_idx;
      prefill(i, 0);
      arm(i, 512, 1'b1);
      repeat (8) @(negedge clk);
      rx_en = 0;
      gen(60); send(60, 0, 0, 0);
      chk(mem[RING_BASE + 4 * i] === arm_word(512, 1, i == NDESC - 1), "R12", "status kept",
          mem[RING_BASE + 4 * i], arm_word(512, 1, i == NDESC - 1));
      chk(miss_count == 0, "R12", "miss count unchanged", miss_count, 0);
      check_untouched(i, "R12");
      rx_en = 1;
    end

    for (int n = 0; n < 40; n++) begin
      int len = $urandom_range(1, 300);
      int bsz = ($urandom_range(0, 3) == 0) ? $urandom_range(1, 300) : 512;
      bit crc = ($urandom_range(0, 4) == 0);
      run_frame(len, bsz, crc, 1, "R3", "R2");
    end

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule